// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral Timer

This block decides the cycle in which a half-duplex Ethernet-style MAC may begin sending a frame that is waiting. It watches one medium-activity input, which is high whenever the line carries traffic in either direction. Each time that input goes quiet, the block times an inter-frame gap. When the gap has passed and a frame is ready, it raises a transmit-permit output. That output stays high until the frame-ready input is withdrawn.

The gap is timed in one of two modes. In the single-stage mode, one 8-bit value sets the wait, minus a fixed offset of three clocks. In the split mode, two 8-bit values are timed back to back. Line activity during the first stage starts the wait over. Activity during the second stage is ignored, because the frame is already committed at that point. In full-duplex operation there is no deferral: a ready frame is permitted at once. The timer keeps running while the line is quiet even when no frame is waiting. A frame that shows up after the gap has already passed is therefore released on the next clock.

Top module: `deferTimer`

## Requirements
- R1: While `rstN` is low, `txPermit` is 0 whatever the other inputs are. After reset the gap timer starts from zero.
- R2: In single-stage mode (`twoPartMode` = 0), with `frameReady` held high, `txPermit` rises at edge N+1, where N = `singleGap` − 3. Edge 1 is the first rising edge at which `mediumBusy` is sampled low.
- R3: In single-stage mode, a `singleGap` value of 0, 1, 2 or 3 gives N = 0 instead of wrapping, so `txPermit` rises at edge 1.
- R4: In split mode (`twoPartMode` = 1), with `frameReady` held high, `txPermit` rises at edge `gapPart1` + max(`gapPart2`, 1) + 1, counted as in R2.
- R5: `mediumBusy` sampled high during the single-stage wait, or during the first stage of split mode, clears the count. Timing restarts at the next quiet edge.
- R6: `mediumBusy` during the second stage of split mode has no effect on the edge at which `txPermit` rises.
- R7: With `fullDuplex` = 1, `txPermit` is high one edge after `frameReady` is sampled high. This holds whatever `mediumBusy` and the gap values are.
- R8: Once high, `txPermit` stays high while `frameReady` stays high, even if `mediumBusy` rises. It drops one edge after `frameReady` is sampled low.
- R9: The gap is timed with `frameReady` low. If the gap has already passed when `frameReady` is sampled high, `txPermit` is high after that same edge.
- R10: When `frameReady` drops, the timer re-arms. A new frame then waits a full fresh gap, counted from the edge that sampled the drop.
- R11: Suppose the gap has passed and `frameReady` and `mediumBusy` are first sampled high at the same edge. In split mode the frame is permitted at that edge. In single-stage mode it is not permitted, and the gap restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rstN | input | 1 | Synchronous active-low reset |
| frameReady | input | 1 | A frame is waiting to be sent |
| mediumBusy | input | 1 | Transmit or receive activity on the line |
| fullDuplex | input | 1 | 1 = full duplex, no deferral |
| twoPartMode | input | 1 | 0 = single-stage gap, 1 = split two-stage gap |
| singleGap | input | 8 | Single-stage gap value (wait is value − 3) |
| gapPart1 | input | 8 | First-stage (restartable) gap value |
| gapPart2 | input | 8 | Second-stage (committed) gap value |
| txPermit | output | 1 | Transmission may start |

## Verification
Two events can fall on one edge: a frame becoming ready and the line turning busy, both in the first cycle after the gap has passed. The bench provokes this by letting the gap run out with no frame waiting. It then raises `frameReady` and `mediumBusy` together on one negative edge. In split mode it expects the permit on the next edge. In single-stage mode it expects no permit, followed by a full fresh gap once the line is quiet again. Busy pulses are also placed on either side of the boundary between the two split stages. These show that only the first stage restarts.

// File: rtl/deferPkg.sv
package deferPkg;

  typedef enum logic [1:0] {
    ST_COUNT  = 2'd0,
    ST_PART2  = 2'd1,
    ST_READY  = 2'd2,
    ST_PERMIT = 2'd3
  } deferState_t;

  typedef struct packed {
    logic clr;
    logic inc;
  } gapStrobe_t;

endpackage

// File: rtl/deferDatapath.sv
module deferDatapath #(
  parameter int GAP_W  = 8,
  parameter int OFFSET = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  deferPkg::gapStrobe_t strobe,
  input  logic                twoPartMode,
  input  logic [GAP_W-1:0]    singleGap,
  input  logic [GAP_W-1:0]    gapPart1,
  input  logic [GAP_W-1:0]    gapPart2,
  output logic                hitFirst,
  output logic                hitTotal
);
  localparam int CNT_W = GAP_W + 1;
  localparam logic [CNT_W-1:0] OFFS = CNT_W'(OFFSET);

  logic [CNT_W-1:0] quietCnt;
  logic [CNT_W-1:0] singleEff;
  logic [CNT_W-1:0] firstLimit;
  logic [CNT_W-1:0] totalLimit;

  // single-stage wait, clamped at zero instead of wrapping
  always_comb begin
    if ({1'b0, singleGap} > OFFS) singleEff = {1'b0, singleGap} - OFFS;
    else                          singleEff = '0;
  end

  assign firstLimit = twoPartMode ? {1'b0, gapPart1} : singleEff;
  assign totalLimit = {1'b0, gapPart1} + {1'b0, gapPart2};

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clr) quietCnt <= '0;
    else if (strobe.inc && quietCnt != '1) quietCnt <= quietCnt + 1'b1;
  end

  assign hitFirst = quietCnt >= firstLimit;
  assign hitTotal = quietCnt >= totalLimit;
endmodule

// File: rtl/deferControl.sv
module deferControl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameReady,
  input  logic                 mediumBusy,
  input  logic                 fullDuplex,
  input  logic                 twoPartMode,
  input  logic                 hitFirst,
  input  logic                 hitTotal,
  output deferPkg::gapStrobe_t strobe,
  output logic                 txPermit
);
  import deferPkg::*;

  deferState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_COUNT: begin
        if (mediumBusy) begin
          strobe.clr = 1'b1;
        end else begin
          strobe.inc = 1'b1;
          if (hitFirst) begin
            if (twoPartMode)     nextState = ST_PART2;
            else if (frameReady) nextState = ST_PERMIT;
            else                 nextState = ST_READY;
          end
        end
      end
      ST_PART2: begin
        strobe.inc = 1'b1;  // line activity ignored: frame committed
        if (hitTotal) nextState = frameReady ? ST_PERMIT : ST_READY;
      end
      ST_READY: begin
        if (frameReady && (!mediumBusy || twoPartMode)) begin
          nextState = ST_PERMIT;
        end else if (mediumBusy) begin
          nextState  = ST_COUNT;
          strobe.clr = 1'b1;
        end
      end
      ST_PERMIT: begin
        if (!frameReady) begin
          nextState  = ST_COUNT;
          strobe.clr = 1'b1;
        end
      end
      default: nextState = ST_COUNT;
    endcase
    if (fullDuplex && frameReady) nextState = ST_PERMIT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_COUNT;
    else       state <= nextState;
  end

  assign txPermit = (state == ST_PERMIT);
endmodule

// File: rtl/deferTimer.sv
module deferTimer #(
  parameter int GAP_W  = 8,
  parameter int OFFSET = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameReady,
  input  logic             mediumBusy,
  input  logic             fullDuplex,
  input  logic             twoPartMode,
  input  logic [GAP_W-1:0] singleGap,
  input  logic [GAP_W-1:0] gapPart1,
  input  logic [GAP_W-1:0] gapPart2,
  output logic             txPermit
);
  deferPkg::gapStrobe_t strobe;
  logic hitFirst, hitTotal;

  deferControl ctrl (
    .clk(clk), .rstN(rstN), .frameReady(frameReady), .mediumBusy(mediumBusy),
    .fullDuplex(fullDuplex), .twoPartMode(twoPartMode),
    .hitFirst(hitFirst), .hitTotal(hitTotal),
    .strobe(strobe), .txPermit(txPermit)
  );

  deferDatapath #(.GAP_W(GAP_W), .OFFSET(OFFSET)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .twoPartMode(twoPartMode),
    .singleGap(singleGap), .gapPart1(gapPart1), .gapPart2(gapPart2),
    .hitFirst(hitFirst), .hitTotal(hitTotal)
  );
endmodule

// File: rtl/deferTimerChecker.sv
module deferTimerChecker (
  input logic clk,
  input logic rstN,
  input logic frameReady,
  input logic mediumBusy,
  input logic fullDuplex,
  input logic twoPartMode,
  input logic txPermit
);
  a_r8_hold_while_ready: assert property (@(posedge clk) disable iff (!rstN)
    frameReady && txPermit |=> txPermit);

  a_r8_drop_on_release: assert property (@(posedge clk) disable iff (!rstN)
    !frameReady |=> !txPermit);

  a_r7_full_duplex_grant: assert property (@(posedge clk) disable iff (!rstN)
    fullDuplex && frameReady |=> txPermit);

  a_r5_busy_blocks_single: assert property (@(posedge clk) disable iff (!rstN)
    !fullDuplex && !twoPartMode && mediumBusy && !txPermit |=> !txPermit);

  a_r1_grant_needs_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txPermit) |-> $past(frameReady));
endmodule

bind deferTimer deferTimerChecker chk (
  .clk(clk), .rstN(rstN), .frameReady(frameReady), .mediumBusy(mediumBusy),
  .fullDuplex(fullDuplex), .twoPartMode(twoPartMode), .txPermit(txPermit)
);

// File: tb/deferTimer_test.sv
module deferTimer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameReady = 1'b0;
  logic mediumBusy = 1'b1;
  logic fullDuplex = 1'b0;
  logic twoPartMode = 1'b0;
  logic [7:0] singleGap = 8'd12;
  logic [7:0] gapPart1 = 8'd8;
  logic [7:0] gapPart2 = 8'd4;
  logic txPermit;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  deferTimer uut (
    .clk(clk), .rstN(rstN), .frameReady(frameReady), .mediumBusy(mediumBusy),
    .fullDuplex(fullDuplex), .twoPartMode(twoPartMode), .singleGap(singleGap),
    .gapPart1(gapPart1), .gapPart2(gapPart2), .txPermit(txPermit)
  );

  // vector: {twoPart, singleGap, gapPart1, gapPart2, expected edge (10b)}
  localparam int NV = 8;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 8'd12,  8'd0,   8'd0,   10'd10},   // R2
    {1'b0, 8'd3,   8'd0,   8'd0,   10'd1},    // R3
    {1'b0, 8'd1,   8'd0,   8'd0,   10'd1},    // R3
    {1'b0, 8'd0,   8'd0,   8'd0,   10'd1},    // R3
    {1'b1, 8'd0,   8'd8,   8'd4,   10'd13},   // R4
    {1'b1, 8'd0,   8'd0,   8'd1,   10'd2},    // R4
    {1'b0, 8'd255, 8'd0,   8'd0,   10'd253},  // R2
    {1'b1, 8'd0,   8'd200, 8'd100, 10'd301}   // R4
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one gap: busy, frame ready, then quiet, optional busy pulse.
  task automatic runGap(input bit two, input logic [7:0] s, input logic [7:0] p1,
                        input logic [7:0] p2, input int pulseAt, input int pulseLen,
                        input int exp, input string req);
    int got = 0;
    frameReady = 1'b0; mediumBusy = 1'b1;
    twoPartMode = two; singleGap = s; gapPart1 = p1; gapPart2 = p2;
    tick(); tick();
    frameReady = 1'b1;
    tick();
    mediumBusy = 1'b0;
    for (int k = 1; k <= exp + 5 && got == 0; k++) begin
      tick();
      if (txPermit) got = k;
      if (pulseAt != 0 && k == pulseAt) mediumBusy = 1'b1;
      if (pulseAt != 0 && k == pulseAt + pulseLen) mediumBusy = 1'b0;
    end
    check(got == exp, req, got, exp);
    frameReady = 1'b0; mediumBusy = 1'b1;
    tick();
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds permit low even with full duplex and a ready frame
    rstN = 1'b0; frameReady = 1'b1; fullDuplex = 1'b1;
    tick(); tick();
    check(txPermit == 1'b0, "R1", txPermit, 0);
    frameReady = 1'b0; fullDuplex = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
    check(txPermit == 1'b0, "R1", txPermit, 0);

    // table: R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      runGap(VEC[i][34], VEC[i][33:26], VEC[i][25:18], VEC[i][17:10], 0, 0,
             int'(VEC[i][9:0]), VEC[i][34] ? "R4" : (VEC[i][33:26] <= 8'd3 ? "R3" : "R2"));
    end

    // R5: restart during single wait (N=5, busy edges 4,5 -> permit 11)
    runGap(1'b0, 8'd8, 8'd0, 8'd0, 3, 2, 11, "R5");
    // R5: restart during first stage (busy edge 7 -> 7+16)
    runGap(1'b1, 8'd0, 8'd10, 8'd5, 6, 1, 23, "R5");
    // R6: busy during second stage ignored
    runGap(1'b1, 8'd0, 8'd4, 8'd10, 6, 2, 15, "R6");

    // R7: full duplex grants at once despite busy line
    fullDuplex = 1'b1; mediumBusy = 1'b1; frameReady = 1'b0; singleGap = 8'd200;
    tick();
    frameReady = 1'b1;
    tick();
    check(txPermit == 1'b1, "R7", txPermit, 1);
    frameReady = 1'b0;
    tick();
    check(txPermit == 1'b0, "R8", txPermit, 0);
    fullDuplex = 1'b0;

    // R8: hold through busy
    twoPartMode = 1'b0; singleGap = 8'd3; mediumBusy = 1'b0; frameReady = 1'b1;
    tick(); tick();
    check(txPermit == 1'b1, "R8", txPermit, 1);
    mediumBusy = 1'b1;
    for (int j = 0; j < 4; j++) begin
      tick();
      check(txPermit == 1'b1, "R8", txPermit, 1);
    end
    frameReady = 1'b0;
    tick();
    check(txPermit == 1'b0, "R8", txPermit, 0);

    // R9: gap elapses with no frame, frame then released at next edge
    singleGap = 8'd12; mediumBusy = 1'b1;
    tick();
    mediumBusy = 1'b0;
    for (int j = 0; j < 15; j++) tick();
    check(txPermit == 1'b0, "R9", txPermit, 0);
    frameReady = 1'b1;
    tick();
    check(txPermit == 1'b1, "R9", txPermit, 1);

    // R10: re-arm after drop, fresh gap of N=5 -> permit at drop+6
    singleGap = 8'd8;
    frameReady = 1'b0;
    tick();
    check(txPermit == 1'b0, "R10", txPermit, 0);
    frameReady = 1'b1;
    for (int j = 0; j < 5; j++) tick();
    check(txPermit == 1'b0, "R10", txPermit, 0);
    tick();
    check(txPermit == 1'b1, "R10", txPermit, 1);

    // R11: frame and busy on the same edge after gap, split mode grants
    twoPartMode = 1'b1; gapPart1 = 8'd2; gapPart2 = 8'd2;
    frameReady = 1'b0; mediumBusy = 1'b1;
    tick(); tick();
    mediumBusy = 1'b0;
    for (int j = 0; j < 20; j++) tick();
    frameReady = 1'b1; mediumBusy = 1'b1;
    tick();
    check(txPermit == 1'b1, "R11", txPermit, 1);

    // R11: same collision in single-stage mode restarts the gap (N=2)
    twoPartMode = 1'b0; singleGap = 8'd5;
    frameReady = 1'b0; mediumBusy = 1'b1;
    tick(); tick();
    mediumBusy = 1'b0;
    for (int j = 0; j < 20; j++) tick();
    frameReady = 1'b1; mediumBusy = 1'b1;
    tick();
    check(txPermit == 1'b0, "R11", txPermit, 0);
    mediumBusy = 1'b0;
    tick(); tick();
    check(txPermit == 1'b0, "R11", txPermit, 0);
    tick();
    check(txPermit == 1'b1, "R11", txPermit, 1);
    frameReady = 1'b0;
    tick();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule